// File: doc/BRIEF.md
# Programmable Reference Divider with Prescaler

This block turns a fast reference clock into the comparison rate of a frequency synthesizer loop. Two down-counters are cascaded. The first is a prescaler whose ratio is chosen from a small table by a 2-bit select. The second is a 10-bit binary divider whose ratio is set by a divide word. The overall ratio is the product of the two. The block can also serve on its own as a plain programmable divider.

Once per overall period the block raises a one-cycle pulse. It also drives a square-ish output that changes level with every pulse, so that output runs at half the pulse rate with an even duty cycle.

The select and the word may change at any time. They are captured only on the clock edge that raises the pulse, so every period runs to its full programmed length. The block does not count a separate enable: every clock cycle is one input cycle.

Top module: `refdiv_chain`

## Requirements
- R1: For a divide word N from 1 to 1023 with the prescaler select at 0, `div_pulse` rises every N clock cycles.
- R2: A divide word of 0 makes the binary divider divide by 1024.
- R3: The 2-bit select chooses the prescaler ratio: code 0 is /1, code 1 is /2, code 2 is /10 and code 3 is /100.
- R4: The pulse period equals the prescaler ratio times the binary ratio, from 1 up to 102400 cycles.
- R5: `div_pulse` stays high for exactly one cycle per period. When the total ratio is 1, it is high on every cycle.
- R6: The select and word are sampled on the clock edge that raises `div_pulse`, and on every reset edge. A change at any other time leaves the current period unchanged and takes effect in the next one.
- R7: `div_sq` inverts on every edge that raises `div_pulse` and holds its level otherwise. It is 0 after reset.
- R8: A synchronous active-high reset clears `div_pulse` and `div_sq` and restarts both stages. The first pulse rises on the R-th clock edge after the last reset edge, where R is the total ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every cycle is one input cycle |
| rst | input | 1 | Synchronous reset, active high |
| ps_sel | input | 2 | Prescaler ratio select (0:/1, 1:/2, 2:/10, 3:/100) |
| div_word | input | 10 | Binary divider ratio; 0 means 1024 |
| div_pulse | output | 1 | One-cycle pulse per overall period |
| div_sq | output | 1 | Level that inverts on each pulse |

## Verification
Two things can fall in the same cycle: the capture of new programming and the terminal-count reload that ends a period. The bench provokes this by changing the word in the last cycle before the pulse rises. It then checks that the period in progress keeps its old length and that the very next period takes the new length. A second case changes the word several cycles before the terminal count, to show that a change made mid-period never shortens the running period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
   // Width needed to hold values 0 .. max_val-1, never below one bit.
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val > 1) ? $clog2(max_val) : 1;
   endfunction

   // Reload value of the binary stage for a given word and word width.
   function automatic int unsigned full_count(input int unsigned word_w);
      return 1 << word_w;
   endfunction
endpackage

// File: rtl/refdiv_capture.sv
module refdiv_capture #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reload,
   input  logic [SEL_W-1:0] sel_in,
   output logic [SEL_W-1:0] sel_act
);
   // Holds the select used for the prescaler's internal wraps in the current period.
   always_ff @(posedge clk) begin
      if (rst || reload) sel_act <= sel_in;
   end
endmodule

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
   parameter int          SEL_W  = 2,
   parameter int unsigned PS_MAX = 100,
   parameter int          PS_W   = 7,
   parameter int unsigned PS_RATIO [2**SEL_W] = '{1, 2, 10, 100}
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reload,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [SEL_W-1:0] sel_act,
   output logic             tick,
   output logic [PS_W-1:0]  pcnt
);
   localparam int NUM_SEL = 2**SEL_W;

   if (PS_MAX == 1) begin : g_bypass
      // Every ratio is 1: the stage reduces to a constant enable.
      assign tick = 1'b1;
      assign pcnt = '0;
   end else begin : g_count
      logic [PS_W-1:0] load_tab [NUM_SEL];
      logic [PS_W-1:0] pcnt_q;

      for (genvar i = 0; i < NUM_SEL; i++) begin : g_tab
         if (PS_RATIO[i] < 1 || PS_RATIO[i] > PS_MAX) begin : g_bad
            $error("prescaler ratio entry out of range");
         end
         assign load_tab[i] = PS_W'(PS_RATIO[i] - 1);
      end

      always_ff @(posedge clk) begin
         if (rst || reload)      pcnt_q <= load_tab[sel_in];
         else if (pcnt_q == '0)  pcnt_q <= load_tab[sel_act];
         else                    pcnt_q <= pcnt_q - 1'b1;
      end

      assign tick = (pcnt_q == '0);
      assign pcnt = pcnt_q;
   end
endmodule

// File: rtl/refdiv_bincount.sv
module refdiv_bincount #(
   parameter int N_W = 10
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tick,
   input  logic [N_W-1:0] word_in,
   output logic           term,
   output logic [N_W:0]   bcnt
);
   import refdiv_pkg::*;
   localparam int unsigned FULL = full_count(N_W);

   logic [N_W:0] load_val;
   logic [N_W:0] bcnt_q;

   // A zero word stands for the full 2**N_W count.
   assign load_val = (word_in == '0) ? (N_W+1)'(FULL) : {1'b0, word_in};
   assign term     = tick && (bcnt_q == (N_W+1)'(1));

   always_ff @(posedge clk) begin
      if (rst || term) bcnt_q <= load_val;
      else if (tick)   bcnt_q <= bcnt_q - 1'b1;
   end

   assign bcnt = bcnt_q;
endmodule

// File: rtl/refdiv_outstage.sv
module refdiv_outstage (
   input  logic clk,
   input  logic rst,
   input  logic term,
   output logic pulse,
   output logic sq
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pulse <= 1'b0;
         sq    <= 1'b0;
      end else begin
         pulse <= term;
         if (term) sq <= ~sq;
      end
   end
endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain #(
   parameter int          N_W    = 10,
   parameter int          SEL_W  = 2,
   parameter int unsigned PS_MAX = 100,
   parameter int unsigned PS_RATIO [2**SEL_W] = '{1, 2, 10, 100}
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] ps_sel,
   input  logic [N_W-1:0]   div_word,
   output logic             div_pulse,
   output logic             div_sq
);
   import refdiv_pkg::*;
   localparam int PS_W = cnt_width(PS_MAX);

   if (N_W < 1 || N_W > 24) begin : g_chk_nw
      $error("N_W out of supported range");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_chk_sel
      $error("SEL_W out of supported range");
   end
   if (PS_MAX < 1) begin : g_chk_max
      $error("PS_MAX must be at least 1");
   end

   logic [SEL_W-1:0] sel_act;
   logic             pre_tick;
   logic             term;
   logic [PS_W-1:0]  pcnt_q;
   logic [N_W:0]     bcnt_q;

   refdiv_capture #(.SEL_W(SEL_W)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .reload  (term),
      .sel_in  (ps_sel),
      .sel_act (sel_act)
   );

   refdiv_prescale #(
      .SEL_W    (SEL_W),
      .PS_MAX   (PS_MAX),
      .PS_W     (PS_W),
      .PS_RATIO (PS_RATIO)
   ) u_pre (
      .clk     (clk),
      .rst     (rst),
      .reload  (term),
      .sel_in  (ps_sel),
      .sel_act (sel_act),
      .tick    (pre_tick),
      .pcnt    (pcnt_q)
   );

   refdiv_bincount #(.N_W(N_W)) u_bin (
      .clk     (clk),
      .rst     (rst),
      .tick    (pre_tick),
      .word_in (div_word),
      .term    (term),
      .bcnt    (bcnt_q)
   );

   refdiv_outstage u_out (
      .clk   (clk),
      .rst   (rst),
      .term  (term),
      .pulse (div_pulse),
      .sq    (div_sq)
   );
endmodule

// File: rtl/refdiv_chain_chk.sv
module refdiv_chain_chk #(
   parameter int          N_W    = 10,
   parameter int          PS_W   = 7,
   parameter int unsigned PS_MAX = 100
) (
   input logic           clk,
   input logic           rst,
   input logic [N_W-1:0] div_word,
   input logic           div_pulse,
   input logic           div_sq,
   input logic [N_W:0]   bcnt,
   input logic [PS_W-1:0] pcnt
);
   localparam logic [N_W:0] FULL = (N_W+1)'(1 << N_W);

   logic ready = 1'b0;
   always_ff @(posedge clk) ready <= !rst;

   // R8: just after reset both outputs are low
   assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
      !ready |-> (!div_pulse && !div_sq));

   // R2: binary stage stays within 1 .. 2**N_W
   assert_bcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
      ready |-> (bcnt >= (N_W+1)'(1) && bcnt <= FULL));

   // R3: prescaler count never reaches its largest ratio
   assert_pcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
      ready |-> (32'(pcnt) < PS_MAX));

   // R6: the edge raising the pulse loads the word present at that edge
   assert_reload_word_R6: assert property (@(posedge clk) disable iff (rst)
      (ready && div_pulse) |->
         (bcnt == (($past(div_word) == '0) ? FULL : {1'b0, $past(div_word)})));

   // R7: square output inverts with each pulse
   assert_sq_toggle_R7: assert property (@(posedge clk) disable iff (rst)
      (ready && div_pulse) |-> (div_sq != $past(div_sq)));

   // R7: square output holds between pulses
   assert_sq_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (ready && !div_pulse) |-> $stable(div_sq));
endmodule

bind refdiv_chain refdiv_chain_chk #(
   .N_W    (N_W),
   .PS_W   (PS_W),
   .PS_MAX (PS_MAX)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .div_word  (div_word),
   .div_pulse (div_pulse),
   .div_sq    (div_sq),
   .bcnt      (bcnt_q),
   .pcnt      (pcnt_q)
);

// File: tb/tb_refdiv_chain.sv
module tb_refdiv_chain;
   localparam int CLK_P    = 10;
   localparam int WD_LIMIT = 190000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] ps_sel = 2'd0;
   logic [9:0] div_word = 10'd5;
   logic       div_pulse;
   logic       div_sq;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit timed_out = 1'b0;

   refdiv_chain dut (
      .clk       (clk),
      .rst       (rst),
      .ps_sel    (ps_sel),
      .div_word  (div_word),
      .div_pulse (div_pulse),
      .div_sq    (div_sq)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc >= WD_LIMIT) timed_out <= 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] s, input logic [9:0] w);
      @(negedge clk);
      rst = 1'b1; ps_sel = s; div_word = w;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // Counts negedges until the pulse is seen high.
   task automatic wait_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!div_pulse && !timed_out);
   endtask

   task automatic sc_reset_state();
      do_reset(2'd0, 10'd5);
      @(negedge clk);
      chk(div_pulse == 1'b0, "R8 pulse low after reset", div_pulse, 0);
      chk(div_sq == 1'b0, "R8 sq low after reset", div_sq, 0);
   endtask

   task automatic sc_ratio(input logic [1:0] s, input logic [9:0] w, input int r, input string req);
      int n;
      do_reset(s, w);
      wait_pulse(n);
      chk(n == r, {req, " first period after reset (R8)"}, n, r);
      wait_pulse(n);
      chk(n == r, {req, " period"}, n, r);
      if (r > 1) begin
         @(negedge clk);
         chk(div_pulse == 1'b0, "R5 pulse is one cycle", div_pulse, 0);
      end
   endtask

   task automatic sc_unity();
      logic prev;
      int   highs = 0;
      int   flips = 0;
      do_reset(2'd0, 10'd1);
      @(negedge clk);
      prev = div_sq;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (div_pulse) highs++;
         if (div_sq != prev) flips++;
         prev = div_sq;
      end
      chk(highs == 6, "R5 ratio 1 pulses every cycle", highs, 6);
      chk(flips == 6, "R7 ratio 1 sq flips every cycle", flips, 6);
   endtask

   task automatic sc_square();
      int n;
      logic s0;
      do_reset(2'd1, 10'd4);
      wait_pulse(n);
      chk(div_sq == 1'b1, "R7 sq high after first pulse", div_sq, 1);
      s0 = div_sq;
      repeat (3) @(negedge clk);
      chk(div_sq == s0, "R7 sq holds between pulses", div_sq, s0);
      wait_pulse(n);
      chk(div_sq == 1'b0, "R7 sq low after second pulse", div_sq, 0);
   endtask

   task automatic sc_change();
      int n;
      do_reset(2'd0, 10'd4);
      wait_pulse(n);
      chk(n == 4, "R6 base period", n, 4);
      repeat (2) @(negedge clk);
      div_word = 10'd9;
      wait_pulse(n);
      chk(n + 2 == 4, "R6 mid-period change ignored", n + 2, 4);
      wait_pulse(n);
      chk(n == 9, "R6 new word applied next period", n, 9);
      repeat (8) @(negedge clk);
      div_word = 10'd6;
      ps_sel   = 2'd1;
      wait_pulse(n);
      chk(n == 1, "R6 change in terminal cycle keeps period", n + 8, 9);
      wait_pulse(n);
      chk(n == 12, "R6 terminal-cycle change applied next", n, 12);
   endtask

   task automatic sc_mid_reset();
      int n;
      do_reset(2'd2, 10'd3);
      repeat (11) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(div_pulse == 1'b0 && div_sq == 1'b0, "R8 mid-run reset clears outputs",
          {div_pulse, div_sq}, 0);
      rst = 1'b0;
      wait_pulse(n);
      chk(n == 30, "R8 restart gives full first period", n, 30);
   endtask

   initial begin
      sc_reset_state();
      sc_ratio(2'd0, 10'd5,    5,     "R1 word 5");
      sc_ratio(2'd0, 10'd1023, 1023,  "R1 word 1023");
      sc_ratio(2'd0, 10'd0,    1024,  "R2 word 0");
      sc_ratio(2'd1, 10'd3,    6,     "R3 sel1 R4");
      sc_ratio(2'd2, 10'd7,    70,    "R3 sel2 R4");
      sc_ratio(2'd3, 10'd2,    200,   "R3 sel3 R4");
      sc_unity();
      sc_square();
      sc_change();
      sc_mid_reset();
      begin
         int n;
         do_reset(2'd3, 10'd0);
         wait_pulse(n);
         chk(n == 102400, "R4 largest ratio", n, 102400);
      end
      if (timed_out) chk(1'b0, "watchdog expired", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule